// File: doc/BRIEF.md
# Multi-Size Translation Lookaside Buffer

This block is a fully associative store of 64 cached address translations. Each entry can map one of three page sizes: a 1MB section, a 64kB large page or a 4kB small page. A 32-bit virtual address on the lookup port is compared against every valid entry in the same cycle. Each entry uses only the address bits above its own page size. On a hit the block returns the physical address, the 4-bit domain, the 2-bit permission field that applies to the address, and the cacheable and bufferable flags.

A table walker outside this block writes a new entry through the refill port once it has resolved a miss. The slot to overwrite comes from a round-robin pointer that steps through all 64 locations. Two maintenance operations are available. A flush empties the whole buffer. A purge takes one virtual address and invalidates only the entries that translate it. The contents stay in place until one of these operations or an overwrite removes them.

Top module: `vtlb_top`

## Requirements
- R1: After reset every entry is invalid, so no lookup hits until a refill has been written.
- R2: Lookup is combinational: hit and all result outputs follow lookupVa in the same cycle. An entry refilled at one clock edge is visible to lookups right after that edge.
- R3: A section entry (fillSize = 2) matches when lookupVa[31:20] equals its stored tag bits [19:8]. It returns physAddr = {ppn[19:8], lookupVa[19:0]} and perm = stored perm[1:0].
- R4: A large-page entry (fillSize = 1) matches on lookupVa[31:16]. It returns physAddr = {ppn[19:4], lookupVa[15:0]} and the permission quarter q = lookupVa[15:14], taken from stored perm[2q+1:2q].
- R5: A small-page entry (fillSize = 0) matches on lookupVa[31:12]. It returns physAddr = {ppn, lookupVa[11:0]} and the permission quarter q = lookupVa[11:10], taken from stored perm[2q+1:2q].
- R6: On a hit, domain, cacheable and bufferable return the values written with the matching entry.
- R7: A refill with fillSize = 3 (reserved) takes a slot and advances the pointer, but the resulting entry never matches any address.
- R8: Refills are written to slots in strict order 0, 1, ..., 63, 0, and so on. The 65th refill after any point overwrites the entry written by the 1st refill, and the other 63 entries survive.
- R9: A purge invalidates every valid entry that matches purgeVa at its own page size and leaves all others unchanged. If a purge and a refill occur in the same cycle, the purge acts on the old contents and the refill is still written.
- R10: A flush invalidates all entries in one cycle. A refill in the same cycle is dropped and does not advance the pointer.
- R11: On a miss, physAddr, domain, perm, cacheable and bufferable are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupVa | input | 32 | Virtual address to translate |
| hit | output | 1 | A valid entry matches lookupVa |
| physAddr | output | 32 | Translated physical address |
| domain | output | 4 | Domain of the matching entry |
| perm | output | 2 | Permission field that applies to lookupVa |
| cacheable | output | 1 | Cacheable flag of the matching entry |
| bufferable | output | 1 | Bufferable flag of the matching entry |
| fillEn | input | 1 | Write a new entry at the round-robin slot |
| fillVpn | input | 20 | Virtual address bits 31:12 of the new entry |
| fillPpn | input | 20 | Physical address bits 31:12 of the new entry |
| fillSize | input | 2 | 0 small, 1 large, 2 section, 3 reserved |
| fillDomain | input | 4 | Domain of the new entry |
| fillPerm | input | 8 | Four 2-bit permission fields; a section uses bits 1:0 |
| fillC | input | 1 | Cacheable flag of the new entry |
| fillB | input | 1 | Bufferable flag of the new entry |
| purgeEn | input | 1 | Invalidate entries that translate purgeVa |
| purgeVa | input | 32 | Address to purge |
| flushEn | input | 1 | Invalidate all entries |

## Verification
The bench places a section, a large page and a small page side by side and probes just inside and just outside each one. A design that compared too many or too few tag bits would then hit on a neighbour or miss inside its own page. Every quarter of each page is probed, which catches a swapped or mis-shifted selection of the permission field.

The bench purges one small page that shares a 1MB region with another small page. A purge done at section size would remove both. It also issues a purge and a refill of the same address in one cycle, and a flush together with a refill. Mishandling either collision leaves a stale entry or a phantom one.

A run of 65 refills checks that exactly the oldest entry is lost. An off-by-one in the wrap, or a pointer that moves on a dropped refill, would evict the wrong entry.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

  localparam int VA_W     = 32;
  localparam int SMALL_SH = 12;
  localparam int LARGE_SH = 16;
  localparam int SECT_SH  = 20;
  localparam int TAG_W    = VA_W - SMALL_SH;

  typedef enum logic [1:0] {
    PG_SMALL   = 2'd0,
    PG_LARGE   = 2'd1,
    PG_SECTION = 2'd2,
    PG_RSVD    = 2'd3
  } pgSize_e;

  typedef struct packed {
    logic             valid;
    pgSize_e          size;
    logic [TAG_W-1:0] vTag;
    logic [TAG_W-1:0] pTag;
    logic [3:0]       dom;
    logic [7:0]       perm;
    logic             c;
    logic             b;
  } tlbEntry_t;

  typedef struct packed {
    logic wrEn;
    logic flushAll;
    logic purge;
  } tlbStrobe_t;

  function automatic logic vaMatch(tlbEntry_t e, logic [VA_W-1:0] va);
    case (e.size)
      PG_SMALL:   return e.vTag == va[VA_W-1:SMALL_SH];
      PG_LARGE:   return e.vTag[TAG_W-1:LARGE_SH-SMALL_SH] == va[VA_W-1:LARGE_SH];
      PG_SECTION: return e.vTag[TAG_W-1:SECT_SH-SMALL_SH] == va[VA_W-1:SECT_SH];
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/vtlb_ctrl.sv
module vtlb_ctrl
  import vtlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fillEn,
  input  logic             purgeEn,
  input  logic             flushEn,
  output tlbStrobe_t       strobe,
  output logic [IDX_W-1:0] wrIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rrPtr;

  // flush wins over both refill and purge
  always_comb begin
    strobe.flushAll = flushEn;
    strobe.wrEn     = fillEn && !flushEn;
    strobe.purge    = purgeEn && !flushEn;
  end

  assign wrIdx = rrPtr;

  always_ff @(posedge clk) begin
    if (!rstN)
      rrPtr <= '0;
    else if (strobe.wrEn)
      rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
  end

endmodule

// File: rtl/vtlb_array.sv
module vtlb_array
  import vtlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrobe_t       strobe,
  input  logic [IDX_W-1:0] wrIdx,
  input  tlbEntry_t        newEnt,
  input  logic [VA_W-1:0]  purgeVa,
  input  logic [VA_W-1:0]  lookupVa,
  output logic             hit,
  output logic [VA_W-1:0]  physAddr,
  output logic [3:0]       domain,
  output logic [1:0]       perm,
  output logic             cacheable,
  output logic             bufferable
);

  tlbEntry_t          ent [ENTRIES];
  logic [ENTRIES-1:0] lkHit;
  logic [ENTRIES-1:0] pgHit;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lkHit[i] = ent[i].valid && vaMatch(ent[i], lookupVa);
    assign pgHit[i] = ent[i].valid && vaMatch(ent[i], purgeVa);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (!rstN)
        ent[i] <= '0;
      else if (strobe.flushAll)
        ent[i].valid <= 1'b0;
      else if (strobe.wrEn && wrIdx == IDX_W'(i))
        ent[i] <= newEnt;
      else if (strobe.purge && pgHit[i])
        ent[i].valid <= 1'b0;
    end
  end

  tlbEntry_t  sel;
  logic       found;
  logic [1:0] quarter;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && lkHit[i]) begin
        sel   = ent[i];
        found = 1'b1;
      end
    end
  end

  always_comb begin
    hit        = found;
    domain     = sel.dom;
    cacheable  = sel.c;
    bufferable = sel.b;
    quarter    = 2'd0;
    case (sel.size)
      PG_SECTION: physAddr = {sel.pTag[TAG_W-1:SECT_SH-SMALL_SH], lookupVa[SECT_SH-1:0]};
      PG_LARGE: begin
        physAddr = {sel.pTag[TAG_W-1:LARGE_SH-SMALL_SH], lookupVa[LARGE_SH-1:0]};
        quarter  = lookupVa[LARGE_SH-1:LARGE_SH-2];
      end
      default: begin
        physAddr = {sel.pTag, lookupVa[SMALL_SH-1:0]};
        quarter  = lookupVa[SMALL_SH-1:SMALL_SH-2];
      end
    endcase
    case (quarter)
      2'd0:    perm = sel.perm[1:0];
      2'd1:    perm = sel.perm[3:2];
      2'd2:    perm = sel.perm[5:4];
      default: perm = sel.perm[7:6];
    endcase
    if (!found) physAddr = '0;
  end

endmodule

// File: rtl/vtlb_top.sv
module vtlb_top
  import vtlb_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] lookupVa,
  output logic        hit,
  output logic [31:0] physAddr,
  output logic [3:0]  domain,
  output logic [1:0]  perm,
  output logic        cacheable,
  output logic        bufferable,
  input  logic        fillEn,
  input  logic [19:0] fillVpn,
  input  logic [19:0] fillPpn,
  input  logic [1:0]  fillSize,
  input  logic [3:0]  fillDomain,
  input  logic [7:0]  fillPerm,
  input  logic        fillC,
  input  logic        fillB,
  input  logic        purgeEn,
  input  logic [31:0] purgeVa,
  input  logic        flushEn
);

  localparam int IDX_W = $clog2(ENTRIES);

  tlbStrobe_t       strobe;
  logic [IDX_W-1:0] wrIdx;
  tlbEntry_t        newEnt;

  always_comb begin
    newEnt.valid = 1'b1;
    newEnt.size  = pgSize_e'(fillSize);
    newEnt.vTag  = fillVpn;
    newEnt.pTag  = fillPpn;
    newEnt.dom   = fillDomain;
    newEnt.perm  = fillPerm;
    newEnt.c     = fillC;
    newEnt.b     = fillB;
  end

  vtlb_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .fillEn(fillEn), .purgeEn(purgeEn),
    .flushEn(flushEn), .strobe(strobe), .wrIdx(wrIdx)
  );

  vtlb_array #(.ENTRIES(ENTRIES)) u_array (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx), .newEnt(newEnt),
    .purgeVa(purgeVa), .lookupVa(lookupVa), .hit(hit), .physAddr(physAddr),
    .domain(domain), .perm(perm), .cacheable(cacheable), .bufferable(bufferable)
  );

endmodule

// File: rtl/vtlb_chk.sv
module vtlb_chk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] lookupVa,
  input logic        hit,
  input logic [31:0] physAddr,
  input logic [3:0]  domain,
  input logic [1:0]  perm,
  input logic        cacheable,
  input logic        bufferable,
  input logic        fillEn,
  input logic [19:0] fillVpn,
  input logic [1:0]  fillSize,
  input logic        purgeEn,
  input logic [31:0] purgeVa,
  input logic        flushEn
);

  // R1: nothing hits right after reset is released
  a_r1_empty_after_reset: assert property (@(posedge clk)
    $rose(rstN) |-> !hit);

  // R2: a refill is visible on the next cycle
  a_r2_fill_visible: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && !flushEn && fillSize != 2'd3) |=>
      (hit || lookupVa[31:12] != $past(fillVpn)));

  // R5: the 4kB offset always passes through untranslated
  a_r5_low_offset: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> physAddr[11:0] == lookupVa[11:0]);

  // R9: a purged address misses afterwards
  a_r9_purge_gone: assert property (@(posedge clk) disable iff (!rstN)
    (purgeEn && !fillEn && !flushEn) |=>
      !(hit && lookupVa == $past(purgeVa)));

  // R10: nothing survives a flush
  a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rstN)
    flushEn |=> !hit);

  // R11: a miss drives zero results
  a_r11_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (physAddr == '0 && domain == '0 && perm == '0 &&
              !cacheable && !bufferable));

endmodule

bind vtlb_top vtlb_chk u_chk (
  .clk(clk), .rstN(rstN), .lookupVa(lookupVa), .hit(hit), .physAddr(physAddr),
  .domain(domain), .perm(perm), .cacheable(cacheable), .bufferable(bufferable),
  .fillEn(fillEn), .fillVpn(fillVpn), .fillSize(fillSize), .purgeEn(purgeEn),
  .purgeVa(purgeVa), .flushEn(flushEn)
);

// File: tb/sim_vtlb_top.sv
module sim_vtlb_top;

  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lookupVa = '0;
  logic        hit;
  logic [31:0] physAddr;
  logic [3:0]  domain;
  logic [1:0]  perm;
  logic        cacheable, bufferable;
  logic        fillEn = 1'b0;
  logic [19:0] fillVpn = '0, fillPpn = '0;
  logic [1:0]  fillSize = '0;
  logic [3:0]  fillDomain = '0;
  logic [7:0]  fillPerm = '0;
  logic        fillC = 1'b0, fillB = 1'b0;
  logic        purgeEn = 1'b0;
  logic [31:0] purgeVa = '0;
  logic        flushEn = 1'b0;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vtlb_top u0 (.*);

  // bench model
  bit          mValid [N];
  logic [1:0]  mSize [N];
  logic [31:0] mVa [N], mPa [N];
  logic [3:0]  mDom [N];
  logic [7:0]  mPerm [N];
  logic        mC [N], mB [N];
  int          mPtr = 0;

  function automatic bit mMatch(int i, logic [31:0] va);
    if (!mValid[i]) return 1'b0;
    case (mSize[i])
      2'd0: return mVa[i][31:12] == va[31:12];
      2'd1: return mVa[i][31:16] == va[31:16];
      2'd2: return mVa[i][31:20] == va[31:20];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] offMask(logic [1:0] sz);
    return (sz == 2'd2) ? 32'h000F_FFFF : (sz == 2'd1) ? 32'h0000_FFFF : 32'h0000_0FFF;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic look(logic [31:0] va, string req);
    int k;
    logic [1:0] q;
    logic [1:0] ep;
    lookupVa = va;
    #2;
    k = -1;
    for (int i = 0; i < N; i++) if (k < 0 && mMatch(i, va)) k = i;
    chk(req, 32'(hit), 32'(k >= 0), "hit");
    if (k < 0) begin
      chk("R11", physAddr, 0, "pa on miss");
      chk("R11", {24'h0, domain, perm, cacheable, bufferable}, 0, "fields on miss");
    end else begin
      chk(req, physAddr, (mPa[k] & ~offMask(mSize[k])) | (va & offMask(mSize[k])), "pa");
      q  = (mSize[k] == 2'd2) ? 2'd0 : (mSize[k] == 2'd1) ? va[15:14] : va[11:10];
      ep = mPerm[k][2*q +: 2];
      chk(req, 32'(perm), 32'(ep), "perm");
      chk("R6", {domain, cacheable, bufferable}, {mDom[k], mC[k], mB[k]}, "dom/c/b");
    end
  endtask

  task automatic op(bit f, logic [31:0] va, logic [31:0] pa, logic [1:0] sz,
                    logic [3:0] dm, logic [7:0] pm, logic c, logic b,
                    bit pg, logic [31:0] pva, bit fl);
    @(negedge clk);
    fillEn = f; fillVpn = va[31:12]; fillPpn = pa[31:12]; fillSize = sz;
    fillDomain = dm; fillPerm = pm; fillC = c; fillB = b;
    purgeEn = pg; purgeVa = pva; flushEn = fl;
    @(posedge clk);
    #1;
    fillEn = 1'b0; purgeEn = 1'b0; flushEn = 1'b0;
    if (fl) begin
      for (int i = 0; i < N; i++) mValid[i] = 1'b0;
    end else begin
      if (pg) for (int i = 0; i < N; i++) if (mMatch(i, pva)) mValid[i] = 1'b0;
      if (f) begin
        mValid[mPtr] = 1'b1; mSize[mPtr] = sz; mVa[mPtr] = {va[31:12], 12'h0};
        mPa[mPtr] = {pa[31:12], 12'h0}; mDom[mPtr] = dm; mPerm[mPtr] = pm;
        mC[mPtr] = c; mB[mPtr] = b;
        mPtr = (mPtr + 1) % N;
      end
    end
  endtask

  task automatic fill(logic [31:0] va, logic [31:0] pa, logic [1:0] sz,
                      logic [3:0] dm, logic [7:0] pm, logic c, logic b);
    op(1'b1, va, pa, sz, dm, pm, c, b, 1'b0, '0, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int sec;
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) mValid[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    look(32'h1234_5678, "R1");
    look(32'h0000_0000, "R1");

    // section, R3
    fill(32'h0030_0000, 32'hABC0_0000, 2'd2, 4'd5, 8'b1110_0110, 1'b1, 1'b0);
    look(32'h0030_0000, "R2");
    look(32'h003F_FFFC, "R3");
    look(32'h0031_2345, "R3");
    look(32'h0040_0000, "R3");
    look(32'h002F_FFFF, "R3");

    // large page, R4
    fill(32'h1234_0000, 32'h5678_0000, 2'd1, 4'd9, 8'b1110_0100, 1'b0, 1'b1);
    for (int q = 0; q < 4; q++) look(32'h1234_0000 + q * 32'h4000 + 32'h123, "R4");
    look(32'h1235_0000, "R4");
    look(32'h1233_FFFF, "R4");

    // small page, R5
    fill(32'h7000_5000, 32'h0000_A000, 2'd0, 4'd15, 8'b0001_1011, 1'b1, 1'b1);
    for (int q = 0; q < 4; q++) look(32'h7000_5000 + q * 32'h400 + 32'h3, "R5");
    look(32'h7000_6000, "R5");
    look(32'h7000_4FFF, "R5");

    // reserved size, R7
    fill(32'h0FF0_0000, 32'h1110_0000, 2'd3, 4'd1, 8'hFF, 1'b1, 1'b1);
    look(32'h0FF0_0000, "R7");
    look(32'h0FF1_2000, "R7");

    // purge granularity, R9
    fill(32'h2000_1000, 32'h3000_1000, 2'd0, 4'd2, 8'h55, 1'b0, 1'b0);
    fill(32'h2000_2000, 32'h3000_2000, 2'd0, 4'd3, 8'hAA, 1'b1, 1'b0);
    op(1'b0, '0, '0, 2'd0, 4'd0, 8'd0, 1'b0, 1'b0, 1'b1, 32'h2000_1ABC, 1'b0);
    look(32'h2000_1000, "R9");
    look(32'h2000_2010, "R9");
    look(32'h0030_0000, "R9");
    // purge and refill of the same address together, R9
    op(1'b1, 32'h2000_2000, 32'h4400_7000, 2'd0, 4'd4, 8'h3C, 1'b0, 1'b1,
       1'b1, 32'h2000_2000, 1'b0);
    look(32'h2000_2FF0, "R9");

    // flush with refill, R10
    op(1'b1, 32'h4440_0000, 32'h5550_0000, 2'd2, 4'd1, 8'h01, 1'b0, 1'b0,
       1'b0, '0, 1'b1);
    look(32'h4440_0000, "R10");
    look(32'h1234_4000, "R10");
    look(32'h7000_5000, "R10");

    // round robin, R8
    for (int i = 0; i < N; i++)
      fill({12'(12'h600 + i), 20'h0}, {12'(12'h900 + i), 20'h0}, 2'd2, 4'(i), 8'(i), 1'b0, 1'b1);
    for (int i = 0; i < N; i++) look({12'(12'h600 + i), 20'h5A5A4}, "R8");
    fill(32'h7FF0_0000, 32'h8FF0_0000, 2'd2, 4'd7, 8'h02, 1'b1, 1'b1);
    look(32'h6000_0000, "R8");
    look(32'h6010_0000, "R8");
    look(32'h63F0_0000, "R8");
    look(32'h7FF8_0000, "R8");

    // random phase
    sec = 12'hA00;
    for (int it = 0; it < 1500; it++) begin
      int r;
      int k;
      r = int'($urandom_range(99));
      k = int'($urandom_range(N - 1));
      if (r < 55) begin
        logic [1:0] sz;
        sz = 2'($urandom_range(3));
        fill({12'(sec), 20'($urandom)}, $urandom, sz, 4'($urandom), 8'($urandom),
             1'($urandom), 1'($urandom));
        sec = (sec + 1) % 4096;
      end else if (r < 70) begin
        logic [31:0] pv;
        pv = mValid[k] ? (mVa[k] | ($urandom & offMask(mSize[k]))) : $urandom;
        op(1'b0, '0, '0, 2'd0, 4'd0, 8'd0, 1'b0, 1'b0, 1'b1, pv, 1'b0);
        look(pv, "R9");
      end else if (r < 72) begin
        op(1'b0, '0, '0, 2'd0, 4'd0, 8'd0, 1'b0, 1'b0, 1'b0, '0, 1'b1);
      end else if (r < 78) begin
        logic [31:0] pv;
        pv = mValid[k] ? mVa[k] : $urandom;
        op(1'b1, {12'(sec), 20'($urandom)}, $urandom, 2'($urandom_range(2)),
           4'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'b1, pv, 1'b0);
        sec = (sec + 1) % 4096;
      end
      k = int'($urandom_range(N - 1));
      if (mValid[k]) look(mVa[k] | ($urandom & offMask(mSize[k])), "R2");
      look($urandom, "R2");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule